// File: doc/BRIEF.md
# Two-Tier Interrupt Enable Controller

This block is the interrupt control point of a small processor core. An 8-bit control register holds a master enable, a group enable for peripheral sources, and one enable/flag pair for each of three core sources: a timer rollover, a rising edge on an external pin, and a level change on a masked set of port pins. Peripheral sources arrive as a vector of already-latched flags, with a matching mask vector. The block combines these inputs into one interrupt request. It also drives a fixed vector address that the core jumps to when it takes the interrupt.

Each core flag latches whenever its event occurs, whether or not its enable, the group enable or the master enable is set. A flag stays set until software writes a 0 to it. Edge and change detection run on the clock of the block. For one cycle after reset, detection is held off so that pins already sitting high do not raise a flag. A small sequencer has two states, `ST_OPEN` (no interrupt in service) and `ST_SERVE` (an interrupt has been taken). It moves from `ST_OPEN` to `ST_SERVE` on an accepted acknowledge and from `ST_SERVE` back to `ST_OPEN` on a return. An accepted acknowledge clears the master enable, and an accepted return sets it again.

Top module: `irq_two_level_ctrl`

## Requirements
- R1: After reset the control register reads 8'h00, `irq_req` is 0 and the sequencer is in `ST_OPEN`.
- R2: Control bits are laid out as: bit 7 master enable, bit 6 group enable, bit 5 timer enable, bit 4 pin enable, bit 3 change enable, bit 2 timer flag, bit 1 pin flag, bit 0 change flag. A write with `reg_wr` high loads all eight bits, and `reg_rdata` shows the new value in the next cycle.
- R3: A one-cycle `tmr_rollover` pulse sets bit 2 in the next cycle, whatever the enables hold, and raises no request while the timer enable is 0.
- R4: A rising edge on `ext_pin` sets bit 1. A falling edge does not.
- R5: A change in either direction on any `port_pins` bit whose `port_chg_mask` bit is 1 sets bit 0. Changes on masked-off pins are ignored. Pin levels present at the first clock after reset raise no flag.
- R6: Flags hold until software writes a 0 to them. If an event and a clearing write fall in the same cycle, the flag stays 1.
- R7: `irq_req` = bit7 & ((bit5 & bit2) | (bit4 & bit1) | (bit3 & bit0) | peripheral term).
- R8: The peripheral term is bit6 & |(`periph_flags` & `periph_mask`). Peripheral flags reach `irq_req` only when both the group enable and the master enable are 1.
- R9: `irq_ack` while `irq_req` is high clears bit 7 and enters `ST_SERVE`, so `irq_req` is low in the next cycle. `irq_ack` with no request pending is ignored. The acknowledge takes priority over a software write to bit 7 in the same cycle.
- R10: `irq_return` in `ST_SERVE` sets bit 7 and re-enters `ST_OPEN`. `irq_return` in `ST_OPEN` is ignored.
- R11: `irq_vector` is constantly 13'h0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| tmr_rollover | input | 1 | One-cycle timer rollover pulse |
| ext_pin | input | 1 | External interrupt pin, already synchronous |
| port_pins | input | NPINS | Port pin levels, already synchronous |
| port_chg_mask | input | NPINS | Per-pin change-detect enable |
| periph_flags | input | NPERIPH | Latched peripheral interrupt flags |
| periph_mask | input | NPERIPH | Per-peripheral enable |
| irq_ack | input | 1 | Core takes the interrupt |
| irq_return | input | 1 | Core returns from the handler |
| irq_req | output | 1 | Interrupt request |
| irq_vector | output | VEC_W | Fixed interrupt entry address |

## Verification
The assertions assume that `tmr_rollover`, `irq_ack` and `irq_return` are pulses aligned to the clock, that `ext_pin` and `port_pins` are already synchronous to `clk`, and that `irq_ack` and `irq_return` never rise in the same cycle. The stimulus drives every input at the falling edge and holds each strobe high for exactly one cycle, and it never overlaps an acknowledge with a return. During the request sweep the pins are held still, so that register writes are the only cause of flag changes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CTL_W    = 8;
    localparam int B_MASTER = 7;
    localparam int B_GROUP  = 6;
    localparam int B_TMR_EN = 5;
    localparam int B_PIN_EN = 4;
    localparam int B_CHG_EN = 3;
    localparam int B_TMR_FL = 2;
    localparam int B_PIN_FL = 1;
    localparam int B_CHG_FL = 0;

    typedef enum logic {
        ST_OPEN  = 1'b0,
        ST_SERVE = 1'b1
    } svc_state_t;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int WIDTH     = 8,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] mask,
    output logic             hit
);
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] diff;
    logic             armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev  <= '0;
            armed <= 1'b0;
        end else begin
            prev  <= din;
            armed <= 1'b1;
        end
    end

    generate
        if (RISE_ONLY) begin : g_rise
            assign diff = din & ~prev;
        end else begin : g_any
            assign diff = din ^ prev;
        end
    endgenerate

    assign hit = armed & (|(diff & mask));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             tmr_evt,
    input  logic             pin_evt,
    input  logic             chg_evt,
    input  logic             ack_take,
    input  logic             ret_take,
    output logic [CTL_W-1:0] ctl
);
    logic [CTL_W-1:0] ctl_nxt;

    always_comb begin
        ctl_nxt = ctl;
        if (wr)
            ctl_nxt = wdata;
        if (ack_take)
            ctl_nxt[B_MASTER] = 1'b0;
        else if (ret_take)
            ctl_nxt[B_MASTER] = 1'b1;
        if (tmr_evt)
            ctl_nxt[B_TMR_FL] = 1'b1;
        if (pin_evt)
            ctl_nxt[B_PIN_FL] = 1'b1;
        if (chg_evt)
            ctl_nxt[B_CHG_FL] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl <= '0;
        else
            ctl <= ctl_nxt;
    end

    AST_TMR_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_evt |=> ctl[B_TMR_FL]); // R3
    AST_PIN_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt |=> ctl[B_PIN_FL]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[B_CHG_FL] && !wr) |=> ctl[B_CHG_FL]); // R6
    AST_ACK_CLEARS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> !ctl[B_MASTER]); // R9
    AST_RET_SETS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && !ack_take) |=> ctl[B_MASTER]); // R10
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_take,
    input  logic       irq_ret,
    output logic       ret_take,
    output svc_state_t state
);
    svc_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OPEN:  if (ack_take) state_nxt = ST_SERVE;
            ST_SERVE: if (!ack_take && irq_ret) state_nxt = ST_OPEN;
            default:  state_nxt = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_OPEN;
        else
            state <= state_nxt;
    end

    always_comb begin
        ret_take = irq_ret && (state == ST_SERVE);
    end

    AST_ACK_ENTERS_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_take |=> (state == ST_SERVE)); // R9
    AST_OPEN_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> !ret_take); // R10
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl
    import irq_pkg::*;
#(
    parameter int          NPINS   = 8,
    parameter int          NPERIPH = 4,
    parameter int          VEC_W   = 13,
    parameter logic [12:0] INT_VEC = 13'h0004
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [CTL_W-1:0]   reg_wdata,
    output logic [CTL_W-1:0]   reg_rdata,
    input  logic               tmr_rollover,
    input  logic               ext_pin,
    input  logic [NPINS-1:0]   port_pins,
    input  logic [NPINS-1:0]   port_chg_mask,
    input  logic [NPERIPH-1:0] periph_flags,
    input  logic [NPERIPH-1:0] periph_mask,
    input  logic               irq_ack,
    input  logic               irq_return,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vector
);
    logic [CTL_W-1:0] ctl;
    logic             pin_evt;
    logic             chg_evt;
    logic             ack_take;
    logic             ret_take;
    logic             core_term;
    logic             group_term;
    svc_state_t       state;

    irq_edge_detect #(.WIDTH(1), .RISE_ONLY(1'b1)) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_pin), .mask(1'b1), .hit(pin_evt)
    );

    irq_edge_detect #(.WIDTH(NPINS), .RISE_ONLY(1'b0)) u_port_chg (
        .clk(clk), .rst_n(rst_n), .din(port_pins), .mask(port_chg_mask), .hit(chg_evt)
    );

    irq_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
        .tmr_evt(tmr_rollover), .pin_evt(pin_evt), .chg_evt(chg_evt),
        .ack_take(ack_take), .ret_take(ret_take), .ctl(ctl)
    );

    irq_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ack_take(ack_take), .irq_ret(irq_return),
        .ret_take(ret_take), .state(state)
    );

    always_comb begin
        core_term  = (ctl[B_TMR_EN] & ctl[B_TMR_FL])
                   | (ctl[B_PIN_EN] & ctl[B_PIN_FL])
                   | (ctl[B_CHG_EN] & ctl[B_CHG_FL]);
        group_term = ctl[B_GROUP] & (|(periph_flags & periph_mask));
        irq_req    = ctl[B_MASTER] & (core_term | group_term);
        ack_take   = irq_ack & irq_req;
    end

    assign reg_rdata  = ctl;
    assign irq_vector = VEC_W'(INT_VEC);

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !irq_req); // R9
    AST_SERVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> (state == ST_SERVE)); // R9
endmodule

// File: tb/irq_two_level_ctrl_test.sv
module irq_two_level_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int NQ = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          tmr_rollover = 1'b0;
    logic          ext_pin = 1'b0;
    logic [NP-1:0] port_pins = '1;
    logic [NP-1:0] port_chg_mask = '1;
    logic [NQ-1:0] periph_flags = '0;
    logic [NQ-1:0] periph_mask = '0;
    logic          irq_ack = 1'b0;
    logic          irq_return = 1'b0;
    logic          irq_req;
    logic [12:0]   irq_vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_two_level_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmr_rollover(tmr_rollover), .ext_pin(ext_pin),
        .port_pins(port_pins), .port_chg_mask(port_chg_mask),
        .periph_flags(periph_flags), .periph_mask(periph_mask),
        .irq_ack(irq_ack), .irq_return(irq_return),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reg", reg_rdata, 8'h00);
        check("R1 req", irq_req, 1'b0);
        check("R11 vector", irq_vector, 13'h0004);
        repeat (3) tick();
        check("R5 no post-reset flag", reg_rdata, 8'h00);

        // R3 timer rollover
        @(negedge clk); tmr_rollover = 1'b1;
        @(negedge clk); tmr_rollover = 1'b0; #1;
        check("R3 flag", reg_rdata, 8'h04);
        check("R3 no req", irq_req, 1'b0);
        // R6 sticky and race
        repeat (5) tick();
        check("R6 sticky", reg_rdata, 8'h04);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h00; tmr_rollover = 1'b1;
        @(negedge clk); reg_wr = 1'b0; tmr_rollover = 1'b0; #1;
        check("R6 event wins", reg_rdata, 8'h04);
        wr_reg(8'h00);
        check("R6 clear", reg_rdata, 8'h00);

        // R4 external pin
        @(negedge clk); ext_pin = 1'b1; tick();
        check("R4 rise", reg_rdata, 8'h02);
        wr_reg(8'h00);
        @(negedge clk); ext_pin = 1'b0; tick(); tick();
        check("R4 fall ignored", reg_rdata, 8'h00);

        // R5 port change
        port_chg_mask = 8'h0F;
        @(negedge clk); port_pins = 8'h7F; tick();
        check("R5 masked pin", reg_rdata, 8'h00);
        @(negedge clk); port_pins = 8'h7D; tick();
        check("R5 fall", reg_rdata, 8'h01);
        wr_reg(8'h00);
        @(negedge clk); port_pins = 8'h7F; tick();
        check("R5 rise", reg_rdata, 8'h01);
        wr_reg(8'h00);

        // R2 R7 R8 sweep
        for (int v = 0; v < 256; v++) begin
            wr_reg(v[7:0]);
            check("R2 readback", reg_rdata, v[7:0]);
            for (int m = 0; m < 2; m++) begin
                periph_mask = (m == 0) ? 4'b0101 : 4'b1111;
                for (int p = 0; p < 16; p++) begin
                    logic [7:0] b;
                    logic       e;
                    b = v[7:0];
                    periph_flags = p[3:0];
                    #1;
                    e = b[7] & ((b[5] & b[2]) | (b[4] & b[1]) | (b[3] & b[0])
                        | (b[6] & (|(p[3:0] & periph_mask))));
                    check("R7 R8 request", irq_req, e);
                end
            end
        end
        periph_flags = '0;
        periph_mask = '0;

        // R9 R10
        wr_reg(8'hA4);
        check("R7 req on", irq_req, 1'b1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        check("R9 master cleared", reg_rdata, 8'h24);
        check("R9 req dropped", irq_req, 1'b0);
        @(negedge clk); irq_return = 1'b1;
        @(negedge clk); irq_return = 1'b0; #1;
        check("R10 master set", reg_rdata, 8'hA4);
        check("R10 req back", irq_req, 1'b1);
        // R9 ack wins over write of master
        @(negedge clk); irq_ack = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hA4;
        @(negedge clk); irq_ack = 1'b0; reg_wr = 1'b0; #1;
        check("R9 ack over write", reg_rdata, 8'h24);
        @(negedge clk); irq_return = 1'b1;
        @(negedge clk); irq_return = 1'b0; #1;
        wr_reg(8'h80);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        check("R9 ack ignored", reg_rdata, 8'h80);
        wr_reg(8'h00);
        @(negedge clk); irq_return = 1'b1;
        @(negedge clk); irq_return = 1'b0; #1;
        check("R10 return ignored", reg_rdata, 8'h00);
        check("R11 vector end", irq_vector, 13'h0004);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule